// File: doc/BRIEF.md
# Configurable Identifier Acceptance Filter

This block decides whether a received frame's identifier is wanted. A frame receiver hands it four identifier bytes and a one-cycle frame-valid strobe. The block compares these bytes against a bank of eight code bytes, each paired with its own mask byte. A mask bit of 1 marks a bit position as don't-care. When at least one filter matches, the block raises a one-cycle accept strobe and reports which filter hit.

The identifier bytes arrive in a fixed packing. For an extended frame the bytes are ordered from byte 0 to byte 3:
- byte 0 holds ID28..ID21.
- byte 1 holds ID20..ID18, then SRR, IDE and ID17..ID15.
- byte 2 holds ID14..ID7.
- byte 3 holds ID6..ID0 and RTR.

For a standard frame:
- byte 0 holds ID10..ID3.
- byte 1 holds ID2..ID0, RTR and IDE, followed by three unused bits.

The comparison is purely bitwise, so the same bank serves both formats.

A 2-bit mode input divides the eight code/mask byte pairs into filters of one of three sizes, or closes the filter entirely. A small state machine with three states registers the decision:
- ST_IDLE is the state when no frame was offered.
- ST_HIT means a frame was offered and matched.
- ST_MISS means a frame was offered and no filter matched.

From every state the machine moves on each clock as follows:
- to ST_HIT when frame_vld is high and some filter matches;
- to ST_MISS when frame_vld is high and nothing matches;
- to ST_IDLE when frame_vld is low.

Top module: `id_accept_filter`

## Requirements
- R1: A filter matches only if every identifier bit whose mask bit is 0 equals the corresponding code bit; identifier bits whose mask bit is 1 never affect the result.
- R2: Mode 2'b00 forms two 32-bit filters: filter 0 compares code/mask bytes 0..3 with identifier bytes 0..3, and filter 1 compares code/mask bytes 4..7 with identifier bytes 0..3.
- R3: Mode 2'b01 forms four 16-bit filters: filter f compares code/mask bytes 2f and 2f+1 with identifier bytes 0 and 1; identifier bytes 2 and 3 are ignored.
- R4: Mode 2'b10 forms eight 8-bit filters: filter f compares code/mask byte f with identifier byte 0; identifier bytes 1..3 are ignored.
- R5: Mode 2'b11 closes the filter: no frame is accepted and hit_idx is left unchanged.
- R6: When several filters match, hit_idx reports the lowest-numbered one.
- R7: accept is high for exactly one cycle, in the cycle after the edge that sampled frame_vld high with a match; accept never rises without frame_vld.
- R8: hit_idx takes a new value only together with an accepted frame; a rejected frame or an idle cycle leaves it unchanged.
- R9: After reset, accept is 0 and hit_idx is 0.
- R10: Frames offered on consecutive cycles are each evaluated, giving back-to-back accept pulses with their own hit_idx.

Byte b of id_bytes, acc_code and acc_mask is bits [8b+7:8b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_vld | input | 1 | One-cycle strobe: id_bytes holds a received identifier |
| id_bytes | input | 32 | Four identifier bytes, byte 0 in bits 7:0 |
| acc_code | input | 64 | Eight acceptance code bytes, byte 0 in bits 7:0 |
| acc_mask | input | 64 | Eight mask bytes, a 1 bit is don't-care |
| acc_mode | input | 2 | Filter granularity: 00 two 32-bit, 01 four 16-bit, 10 eight 8-bit, 11 closed |
| accept | output | 1 | One-cycle pulse: the last offered frame matched |
| hit_idx | output | 3 | Lowest matching filter of the last accepted frame |

## Verification
The bench targets the routing of code bytes onto identifier bytes in each mode.

In 16-bit and 8-bit modes it changes identifier bytes that must be ignored and places the only match on a high filter number. A design that wired the wrong bytes would then miss the frame or report the wrong filter.

It also covers several other cases:
- overlapping matches, which expose a priority encoder that favours the highest index;
- a rejected frame and a closed filter, which expose a hit index that updates on every frame;
- back-to-back strobes, which expose a state machine that swallows a second frame arriving while it still shows the first result;
- a single unmasked differing bit, which exposes an inverted mask.

// File: rtl/acf_pkg.sv
package acf_pkg;

    localparam int unsigned ACF_BYTE_W   = 8;
    localparam int unsigned ACF_CODE_CNT = 8;
    localparam int unsigned ACF_ID_CNT   = 4;

    typedef enum logic [1:0] {
        MODE_W32  = 2'b00,
        MODE_W16  = 2'b01,
        MODE_W8   = 2'b10,
        MODE_SHUT = 2'b11
    } acf_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_HIT  = 2'b01,
        ST_MISS = 2'b10
    } acf_state_e;

endpackage

// File: rtl/acf_byte_cmp.sv
module acf_byte_cmp
    import acf_pkg::*;
#(
    parameter int unsigned BYTE_W   = ACF_BYTE_W,
    parameter int unsigned CODE_CNT = ACF_CODE_CNT,
    parameter int unsigned ID_CNT   = ACF_ID_CNT
) (
    input  acf_mode_e                   mode,
    input  logic [ID_CNT*BYTE_W-1:0]    id_bytes,
    input  logic [CODE_CNT*BYTE_W-1:0]  code,
    input  logic [CODE_CNT*BYTE_W-1:0]  mask,
    output logic [CODE_CNT-1:0]         byte_ok
);

    for (genvar j = 0; j < CODE_CNT; j++) begin : g_byte
        localparam int unsigned SEL32 = j % ID_CNT;
        localparam int unsigned SEL16 = j % 2;
        logic [BYTE_W-1:0] id_pick;
        logic [BYTE_W-1:0] diff;

        always_comb begin
            unique case (mode)
                MODE_W32: id_pick = id_bytes[SEL32*BYTE_W +: BYTE_W];
                MODE_W16: id_pick = id_bytes[SEL16*BYTE_W +: BYTE_W];
                default:  id_pick = id_bytes[0 +: BYTE_W];
            endcase
            diff = (id_pick ^ code[j*BYTE_W +: BYTE_W]) & ~mask[j*BYTE_W +: BYTE_W];
            byte_ok[j] = (diff == '0);
        end
    end

endmodule

// File: rtl/acf_hit_combine.sv
module acf_hit_combine
    import acf_pkg::*;
#(
    parameter int unsigned CODE_CNT = ACF_CODE_CNT
) (
    input  acf_mode_e            mode,
    input  logic [CODE_CNT-1:0]  byte_ok,
    output logic [CODE_CNT-1:0]  hits
);

    localparam int unsigned N32 = CODE_CNT / 4;
    localparam int unsigned N16 = CODE_CNT / 2;

    logic [CODE_CNT-1:0] hit32;
    logic [CODE_CNT-1:0] hit16;

    for (genvar f = 0; f < CODE_CNT; f++) begin : g_filt
        if (f < N32) begin : g_w32
            assign hit32[f] = &byte_ok[4*f +: 4];
        end else begin : g_w32_none
            assign hit32[f] = 1'b0;
        end
        if (f < N16) begin : g_w16
            assign hit16[f] = &byte_ok[2*f +: 2];
        end else begin : g_w16_none
            assign hit16[f] = 1'b0;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_W32:  hits = hit32;
            MODE_W16:  hits = hit16;
            MODE_W8:   hits = byte_ok;
            MODE_SHUT: hits = '0;
        endcase
    end

endmodule

// File: rtl/acf_prio_enc.sv
module acf_prio_enc
    import acf_pkg::*;
#(
    parameter int unsigned CODE_CNT = ACF_CODE_CNT,
    localparam int unsigned IDX_W   = $clog2(CODE_CNT)
) (
    input  logic [CODE_CNT-1:0] hits,
    output logic                any_hit,
    output logic [IDX_W-1:0]    idx
);

    always_comb begin
        idx = '0;
        for (int i = CODE_CNT - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
        any_hit = |hits;
    end

    always_comb begin
        if (any_hit) begin
            AST_PICKS_SET_BIT: assert (hits[idx]); // R6
            AST_NONE_BELOW: assert ((hits & ((CODE_CNT'(1) << idx) - CODE_CNT'(1))) == '0); // R6
        end
    end

endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter
    import acf_pkg::*;
#(
    parameter int unsigned BYTE_W   = ACF_BYTE_W,
    parameter int unsigned CODE_CNT = ACF_CODE_CNT,
    parameter int unsigned ID_CNT   = ACF_ID_CNT,
    localparam int unsigned IDX_W   = $clog2(CODE_CNT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_vld,
    input  logic [ID_CNT*BYTE_W-1:0]    id_bytes,
    input  logic [CODE_CNT*BYTE_W-1:0]  acc_code,
    input  logic [CODE_CNT*BYTE_W-1:0]  acc_mask,
    input  logic [1:0]                  acc_mode,
    output logic                        accept,
    output logic [IDX_W-1:0]            hit_idx
);

    acf_mode_e           mode;
    logic [CODE_CNT-1:0] byte_ok;
    logic [CODE_CNT-1:0] hits;
    logic                any_hit;
    logic [IDX_W-1:0]    win_idx;
    acf_state_e          state_q, state_d;

    assign mode = acf_mode_e'(acc_mode);

    acf_byte_cmp #(.BYTE_W(BYTE_W), .CODE_CNT(CODE_CNT), .ID_CNT(ID_CNT)) u_cmp (
        .mode     (mode),
        .id_bytes (id_bytes),
        .code     (acc_code),
        .mask     (acc_mask),
        .byte_ok  (byte_ok)
    );

    acf_hit_combine #(.CODE_CNT(CODE_CNT)) u_comb (
        .mode    (mode),
        .byte_ok (byte_ok),
        .hits    (hits)
    );

    acf_prio_enc #(.CODE_CNT(CODE_CNT)) u_prio (
        .hits    (hits),
        .any_hit (any_hit),
        .idx     (win_idx)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (!frame_vld)   state_d = ST_IDLE;
                else if (any_hit) state_d = ST_HIT;
                else              state_d = ST_MISS;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hit_idx <= '0;
        else if (state_d == ST_HIT)  hit_idx <= win_idx;
    end

    assign accept = (state_q == ST_HIT);

    AST_ACCEPT_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept) |-> $past(frame_vld)); // R7
    AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> $stable(hit_idx)); // R8
    AST_SHUT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && acc_mode == 2'b11) |=> !accept); // R5
    AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> !accept); // R7

endmodule

// File: tb/tb_id_accept_filter.sv
module tb_id_accept_filter;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] id;
        logic [63:0] code;
        logic [63:0] mask;
        logic        acc;
        logic [2:0]  idx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R2 filter 0 full match
        '{2'b00, 32'hDDCCBBAA, 64'h00000000_DDCCBBAA, 64'h0, 1'b1, 3'd0, 4'd2},
        // R1 masked bit differs is fine (bit0 of byte0 masked)
        '{2'b00, 32'hDDCCBBAA, 64'h00000000_00000001, 64'h00000000_FFFFFFFF, 1'b1, 3'd0, 4'd1},
        // R2 filter 1 matches, filter 0 byte3 differs
        '{2'b00, 32'hDDCCBBAA, 64'hDDCCBBAA_DECCBBAA, 64'h0, 1'b1, 3'd1, 4'd2},
        // R1 unmasked bit0 differs: reject, idx holds 1
        '{2'b00, 32'hDDCCBBAA, 64'h0000000F_00000001, 64'h00000000_FFFFFFFE, 1'b0, 3'd1, 4'd1},
        // R3 filter 2 (bytes 4,5)
        '{2'b01, 32'h12345678, 64'h00005678_00000000, 64'h0, 1'b1, 3'd2, 4'd3},
        // R3 filter 3, id bytes 2,3 ignored
        '{2'b01, 32'hABCD5678, 64'h56780000_00000000, 64'h0, 1'b1, 3'd3, 4'd3},
        // R4 filter 5, id bytes 1..3 ignored
        '{2'b10, 32'h1122335A, 64'h00005A00_00000000, 64'h0, 1'b1, 3'd5, 4'd4},
        // R4 filter 7
        '{2'b10, 32'hFFFFFFA5, 64'hA5000000_00000000, 64'h0, 1'b1, 3'd7, 4'd4},
        // R6 filters 3 and 6 both match: lowest wins
        '{2'b10, 32'h00000033, 64'h00330000_33000000, 64'h0, 1'b1, 3'd3, 4'd6},
        // R5 closed mode with all-don't-care: reject, idx holds 3
        '{2'b11, 32'h00000033, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 1'b0, 3'd3, 4'd5},
        // R6 both 32-bit filters match
        '{2'b00, 32'h89ABCDEF, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 1'b1, 3'd0, 4'd6},
        // R4 mask in 8-bit mode: byte1 upper nibble masked
        '{2'b10, 32'hFFFFFFF0, 64'h0, 64'h00000000_0000F000, 1'b1, 3'd1, 4'd4},
        // R8 reject in 16-bit mode: idx holds 1
        '{2'b01, 32'h0000FFFF, 64'h0, 64'h0, 1'b0, 3'd1, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_vld = 1'b0;
    logic [31:0] id_bytes = '0;
    logic [63:0] acc_code = '0;
    logic [63:0] acc_mask = '0;
    logic [1:0]  acc_mode = 2'b00;
    logic        accept;
    logic [2:0]  hit_idx;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    id_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .id_bytes(id_bytes),
        .acc_code(acc_code), .acc_mask(acc_mask), .acc_mode(acc_mode),
        .accept(accept), .hit_idx(hit_idx)
    );

    task automatic check(input string req, input logic acc_e, input logic [2:0] idx_e);
        checks++;
        if (accept !== acc_e || hit_idx !== idx_e) begin
            fails++;
            $display("FAIL %s: accept=%0b hit_idx=%0d expected accept=%0b hit_idx=%0d",
                     req, accept, hit_idx, acc_e, idx_e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 1'b0, 3'd0);

        // R7: matching setup but no strobe never accepts
        acc_mode = 2'b00; acc_code = '0; acc_mask = '1; id_bytes = 32'h1;
        repeat (2) @(negedge clk);
        check("R7", 1'b0, 3'd0);

        for (int i = 0; i < NV; i++) begin
            acc_mode  = VECS[i].mode;
            id_bytes  = VECS[i].id;
            acc_code  = VECS[i].code;
            acc_mask  = VECS[i].mask;
            frame_vld = 1'b1;
            @(negedge clk);
            frame_vld = 1'b0;
            check($sformatf("R%0d", VECS[i].req), VECS[i].acc, VECS[i].idx);
            @(negedge clk);
        end

        // R7: one-cycle pulse width
        acc_mode = 2'b10; acc_code = 64'h0000_0000_0000_0044; acc_mask = '0;
        id_bytes = 32'h44; frame_vld = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0;
        check("R7", 1'b1, 3'd0);
        @(negedge clk);
        check("R7", 1'b0, 3'd0);

        // R10: back-to-back frames
        acc_code = 64'h0000_0000_0000_2211;
        id_bytes = 32'h22; frame_vld = 1'b1;
        @(negedge clk);
        id_bytes = 32'h11;
        check("R10", 1'b1, 3'd1);
        @(negedge clk);
        frame_vld = 1'b0;
        check("R10", 1'b1, 3'd0);
        @(negedge clk);
        check("R10", 1'b0, 3'd0);

        finish_run();
    end

endmodule